// File: doc/BRIEF.md
# Converter Power-Up Sequencer with Clock Ratio Detection

This block steers a mixed-signal converter from cold start to normal operation. After the chip reset it holds the device in power-down, with filters, modulators and control registers held in reset and the outputs clamped. The device enable input must go high before the configuration port opens. A power-down control bit must be cleared and a master clock valid flag must be raised before converter power is switched on. The outputs stay clamped to the quiescent level throughout.

Once powered, the block times a short ramp. It then measures how many master clock cycles fit in one frame clock period. The frame clock is asynchronous to the master clock and is synchronized first. A measured count is accepted only if it lands within one count of a supported ratio (128, 192, 256, 384, 512, 768 or 1024). Any other count, or a frame clock that does not toggle, restarts the measurement. After a valid ratio the block waits a fixed number of frame periods, 2048 by default, and then releases the clamp and declares normal operation.

The whole block runs in the master clock domain with a synchronous active-high reset. All status outputs are registered.

Top module: `codec_pwrseq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `state_code` is 0, `filt_reset` is 1, `conv_pwr_en` is 0, `out_clamp` is 1, `ctrl_port_en` is 0, `ratio_valid` is 0 and `running` is 0.
- R2: While `chip_enable` is low, the sequencer stays in power-down whatever the other inputs are. `ctrl_port_en` equals the value `chip_enable` had one clock earlier.
- R3: From power-down, with `chip_enable` high and `pdn_bit` 0, the next state is the wait-for-configuration state. That state is held until `mclk_ok` is 1, and it then moves to the ramp state. `conv_pwr_en` is 1 in ramp, measure, settle and run. `out_clamp` is 1 in every state except run.
- R4: The ramp state lasts exactly `RAMP_CYCLES` clock cycles, after which the state is measure.
- R5: In measure, the number of clock cycles between two successive synchronized frame clock rising edges is compared against 128, 192, 256, 384, 512, 768 and 1024 with a tolerance of one count. On a match, `ratio` shows the nominal value, `ratio_valid` rises and the state becomes settle.
- R6: A count that matches no supported ratio, or a window that runs past 1025 cycles without a frame edge, leaves the state in measure with `ratio_valid` 0, and measurement keeps retrying.
- R7: Settle ends after exactly `SETTLE_FRAMES` (default 2048) synchronized frame clock rising edges after `ratio_valid` rises. The state then becomes run, `running` goes to 1 and `out_clamp` goes to 0.
- R8: `pdn_bit` at 1 or `chip_enable` at 0 in any state sends the sequencer to power-down on the next clock: `state_code` 0, `filt_reset` 1, `conv_pwr_en` 0, `out_clamp` 1.
- R9: Losing `mclk_ok` in ramp, measure, settle or run, while `chip_enable` is 1 and `pdn_bit` is 0, returns the sequencer to the wait-for-configuration state on the next clock, with converter power off and `ratio_valid` 0.
- R10: `state_code` encodes power-down 0, wait-for-configuration 1, ramp 2, measure 3, settle 4, run 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all logic runs on its rising edge |
| rst | input | 1 | Synchronous active-high power-on reset |
| chip_enable | input | 1 | Device enable; low holds power-down and closes the configuration port |
| pdn_bit | input | 1 | Power-down control bit from the register file; 1 forces power-down |
| mclk_ok | input | 1 | Master clock valid qualifier |
| frame_clk | input | 1 | Frame (sample-rate) clock, asynchronous |
| state_code | output | 3 | Encoded sequencer state |
| ctrl_port_en | output | 1 | Configuration port access enable |
| filt_reset | output | 1 | Holds filters, modulators and control registers in reset |
| conv_pwr_en | output | 1 | Converter and reference power enable |
| out_clamp | output | 1 | Clamps analog outputs to the quiescent level |
| ratio_valid | output | 1 | A supported clock ratio has been measured |
| ratio | output | 11 | Nominal measured master-to-frame clock ratio |
| running | output | 1 | Normal operation |

## Verification
The bench sweeps every supported ratio plus an off-by-one period. A meter without tolerance would reject that period and stay in measure. It drives an unsupported period and a frame clock that never toggles; a meter that accepts any count, or that never times out its window, would leave measure in one case or hang in the other. It counts the frame edges generated between the rise of `ratio_valid` and the rise of `running`, so a settle counter that is one edge short or one edge long shows up directly. It also forces power-down, clock loss and enable loss from the running state to catch wrong exit targets or converter power left on.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    ST_PWRDN  = 3'd0,
    ST_WAIT   = 3'd1,
    ST_RAMP   = 3'd2,
    ST_MEAS   = 3'd3,
    ST_SETTLE = 3'd4,
    ST_RUN    = 3'd5
  } seq_state_e;

  localparam int unsigned N_RATIOS = 7;

  // supported master/frame clock ratios, index order is irrelevant
  function automatic int unsigned legal_ratio(input int unsigned idx);
    case (idx)
      0:       legal_ratio = 128;
      1:       legal_ratio = 192;
      2:       legal_ratio = 256;
      3:       legal_ratio = 384;
      4:       legal_ratio = 512;
      5:       legal_ratio = 768;
      default: legal_ratio = 1024;
    endcase
  endfunction

endpackage

// File: rtl/frame_edge.sv
module frame_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_o
);
  logic [SYNC_STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      rise_o <= 1'b0;
    end else begin
      sh     <= {sh[SYNC_STAGES-1:0], async_in};
      rise_o <= sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
    end
  end
endmodule

// File: rtl/ratio_meter.sv
module ratio_meter
  import pwrseq_pkg::*;
#(
  parameter int unsigned MAX_RATIO = 1024,
  parameter int unsigned TOL       = 1,
  parameter int unsigned RW        = $clog2(MAX_RATIO + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          edge_i,
  output logic          done_o,
  output logic [RW-1:0] ratio_o
);
  localparam int unsigned LIMIT = MAX_RATIO + TOL;
  localparam int unsigned CW    = $clog2(LIMIT + 2);

  logic          armed;
  logic [CW-1:0] cnt;
  logic          hit;
  logic [RW-1:0] nom;

  always_comb begin
    int unsigned cv;
    cv  = 32'(cnt);
    hit = 1'b0;
    nom = '0;
    for (int i = 0; i < int'(N_RATIOS); i++) begin
      if (cv + TOL >= legal_ratio(i) && cv <= legal_ratio(i) + TOL) begin
        hit = 1'b1;
        nom = RW'(legal_ratio(i));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      armed   <= 1'b0;
      cnt     <= '0;
      done_o  <= 1'b0;
      ratio_o <= '0;
    end else if (edge_i) begin
      armed  <= 1'b1;
      cnt    <= CW'(1);
      done_o <= armed & hit;
      if (armed && hit) ratio_o <= nom;
    end else begin
      done_o <= 1'b0;
      if (armed) begin
        if (cnt > CW'(LIMIT)) begin
          armed <= 1'b0;
          cnt   <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(LIMIT + 1));

  // R5
  done_edge_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(edge_i));
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int unsigned FRAMES = 2048,
  parameter int unsigned CW     = $clog2(FRAMES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic edge_i,
  output logic done_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt    <= '0;
      done_o <= 1'b0;
    end else if (edge_i) begin
      if (cnt == CW'(FRAMES - 1)) begin
        done_o <= 1'b1;
      end else begin
        cnt    <= cnt + CW'(1);
        done_o <= 1'b0;
      end
    end else begin
      done_o <= 1'b0;
    end
  end

  // R7
  settle_edge_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(edge_i));

  // R7
  settle_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(FRAMES - 1));
endmodule

// File: rtl/codec_pwrseq.sv
module codec_pwrseq
  import pwrseq_pkg::*;
#(
  parameter int unsigned RAMP_CYCLES   = 64,
  parameter int unsigned SETTLE_FRAMES = 2048,
  parameter int unsigned MAX_RATIO     = 1024,
  parameter int unsigned RATIO_TOL     = 1,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned RW            = $clog2(MAX_RATIO + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chip_enable,
  input  logic          pdn_bit,
  input  logic          mclk_ok,
  input  logic          frame_clk,
  output logic [2:0]    state_code,
  output logic          ctrl_port_en,
  output logic          filt_reset,
  output logic          conv_pwr_en,
  output logic          out_clamp,
  output logic          ratio_valid,
  output logic [RW-1:0] ratio,
  output logic          running
);
  localparam int unsigned RCW = $clog2(RAMP_CYCLES + 1);

  seq_state_e    state_q, nxt;
  logic [RCW-1:0] ramp_cnt;
  logic          frame_rise;
  logic          meas_done, settle_done;
  logic [RW-1:0] meas_ratio;

  frame_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .async_in (frame_clk),
    .rise_o   (frame_rise)
  );

  ratio_meter #(.MAX_RATIO(MAX_RATIO), .TOL(RATIO_TOL), .RW(RW)) u_meter (
    .clk     (clk),
    .rst     (rst),
    .en      (state_q == ST_MEAS),
    .edge_i  (frame_rise),
    .done_o  (meas_done),
    .ratio_o (meas_ratio)
  );

  settle_timer #(.FRAMES(SETTLE_FRAMES)) u_settle (
    .clk    (clk),
    .rst    (rst),
    .en     (state_q == ST_SETTLE),
    .edge_i (frame_rise),
    .done_o (settle_done)
  );

  always_comb begin
    nxt = state_q;
    if (!chip_enable || pdn_bit) begin
      nxt = ST_PWRDN;
    end else begin
      unique case (state_q)
        ST_PWRDN:  nxt = ST_WAIT;
        ST_WAIT:   if (mclk_ok) nxt = ST_RAMP;
        ST_RAMP:   if (!mclk_ok) nxt = ST_WAIT;
                   else if (ramp_cnt == RCW'(RAMP_CYCLES - 1)) nxt = ST_MEAS;
        ST_MEAS:   if (!mclk_ok) nxt = ST_WAIT;
                   else if (meas_done) nxt = ST_SETTLE;
        ST_SETTLE: if (!mclk_ok) nxt = ST_WAIT;
                   else if (settle_done) nxt = ST_RUN;
        ST_RUN:    if (!mclk_ok) nxt = ST_WAIT;
        default:   nxt = ST_PWRDN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_PWRDN;
      ramp_cnt     <= '0;
      ratio        <= '0;
      state_code   <= 3'd0;
      ctrl_port_en <= 1'b0;
      filt_reset   <= 1'b1;
      conv_pwr_en  <= 1'b0;
      out_clamp    <= 1'b1;
      ratio_valid  <= 1'b0;
      running      <= 1'b0;
    end else begin
      state_q      <= nxt;
      ramp_cnt     <= (state_q == ST_RAMP) ? ramp_cnt + RCW'(1) : '0;
      if (state_q == ST_MEAS && meas_done) ratio <= meas_ratio;
      state_code   <= nxt;
      ctrl_port_en <= chip_enable;
      filt_reset   <= (nxt == ST_PWRDN);
      conv_pwr_en  <= (nxt == ST_RAMP) || (nxt == ST_MEAS) ||
                      (nxt == ST_SETTLE) || (nxt == ST_RUN);
      out_clamp    <= (nxt != ST_RUN);
      ratio_valid  <= (nxt == ST_SETTLE) || (nxt == ST_RUN);
      running      <= (nxt == ST_RUN);
    end
  end

  // R8
  pdn_force_chk: assert property (@(posedge clk) disable iff (rst)
    (pdn_bit || !chip_enable) |=> (state_code == 3'd0 && !conv_pwr_en));

  // R2
  port_follow_chk: assert property (@(posedge clk) disable iff (rst)
    chip_enable |=> ctrl_port_en);

  // R9
  clk_loss_chk: assert property (@(posedge clk) disable iff (rst)
    (!mclk_ok && chip_enable && !pdn_bit && state_q != ST_PWRDN)
      |=> (state_code == 3'd1));

  // R7
  run_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> ($past(state_q) == ST_SETTLE && $past(settle_done)));

  // R5
  ratio_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ratio_valid && $past(ratio_valid)) |-> $stable(ratio));
endmodule

// File: tb/codec_pwrseq_test.sv
module codec_pwrseq_test;
  localparam int RC = 8;
  localparam int SF = 8;

  logic clk = 1'b0;
  logic rst, chip_enable, pdn_bit, mclk_ok, frame_clk;
  logic [2:0]  state_code;
  logic        ctrl_port_en, filt_reset, conv_pwr_en, out_clamp;
  logic        ratio_valid, running;
  logic [10:0] ratio;

  int checks = 0;
  int errors = 0;
  int fper   = 0;
  int fphase = 0;
  int fedges = 0;
  int edge_at_rv  = -1;
  int edge_at_run = -1;
  logic rv_prev = 1'b0, run_prev = 1'b0;

  always #10 clk = ~clk;

  codec_pwrseq #(.RAMP_CYCLES(RC), .SETTLE_FRAMES(SF)) uut (
    .clk(clk), .rst(rst), .chip_enable(chip_enable), .pdn_bit(pdn_bit),
    .mclk_ok(mclk_ok), .frame_clk(frame_clk), .state_code(state_code),
    .ctrl_port_en(ctrl_port_en), .filt_reset(filt_reset),
    .conv_pwr_en(conv_pwr_en), .out_clamp(out_clamp),
    .ratio_valid(ratio_valid), .ratio(ratio), .running(running)
  );

  // frame generator and edge bookkeeping, all on the falling edge
  initial begin
    frame_clk = 1'b0;
    forever begin
      @(negedge clk);
      if (ratio_valid && !rv_prev) edge_at_rv = fedges;
      if (running && !run_prev)    edge_at_run = fedges;
      rv_prev  = ratio_valid;
      run_prev = running;
      if (fper == 0) begin
        frame_clk = 1'b0;
        fphase    = 0;
      end else begin
        fphase = fphase + 1;
        if (fphase >= fper) fphase = 0;
        if (fphase == 0) fedges = fedges + 1;
        frame_clk = (fphase < fper / 2);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bring_up(input int per);
    rst = 1'b1; chip_enable = 1'b1; pdn_bit = 1'b0; mclk_ok = 1'b1;
    fper = per;
    cyc(3);
    rst = 1'b0;
    edge_at_rv = -1; edge_at_run = -1;
  endtask

  // period, accepted, expected nominal ratio
  typedef struct packed { int per; int ok; int exp_ratio; } vec_t;
  localparam vec_t VECS [10] = '{
    '{128, 1, 128}, '{192, 1, 192}, '{256, 1, 256}, '{384, 1, 384},
    '{512, 1, 512}, '{768, 1, 768}, '{1024, 1, 1024}, '{257, 1, 256},
    '{383, 1, 384}, '{300, 0, 0}
  };

  initial begin
    rst = 1'b1; chip_enable = 1'b0; pdn_bit = 1'b1; mclk_ok = 1'b0;
    cyc(3);
    // R1 reset state
    chk("R1 state", state_code, 0);
    chk("R1 filt_reset", filt_reset, 1);
    chk("R1 conv_pwr_en", conv_pwr_en, 0);
    chk("R1 out_clamp", out_clamp, 1);
    chk("R1 ctrl_port_en", ctrl_port_en, 0);
    rst = 1'b0;
    cyc(1);
    chk("R1 running", running, 0);
    chk("R1 ratio_valid", ratio_valid, 0);

    // R2 enable low holds power-down
    pdn_bit = 1'b0; mclk_ok = 1'b1;
    cyc(5);
    chk("R2 state", state_code, 0);
    chk("R2 port closed", ctrl_port_en, 0);

    // R3 wait-for-configuration
    mclk_ok = 1'b0; chip_enable = 1'b1;
    cyc(1);
    chk("R3 state wait", state_code, 1);
    chk("R2 port open", ctrl_port_en, 1);
    cyc(5);
    chk("R3 hold wait", state_code, 1);
    chk("R3 power off in wait", conv_pwr_en, 0);

    // R4 ramp length
    mclk_ok = 1'b1;
    cyc(1);
    chk("R10 ramp code", state_code, 2);
    chk("R3 power on in ramp", conv_pwr_en, 1);
    chk("R3 clamp in ramp", out_clamp, 1);
    cyc(RC - 1);
    chk("R4 last ramp cycle", state_code, 2);
    cyc(1);
    chk("R4 measure after ramp", state_code, 3);

    // R6 missing frame clock
    cyc(3000);
    chk("R6 missing frame state", state_code, 3);
    chk("R6 missing frame valid", ratio_valid, 0);

    // R5 R7 vector sweep
    for (int v = 0; v < 10; v++) begin
      bring_up(VECS[v].per);
      if (VECS[v].ok != 0) begin
        for (int w = 0; w < (SF + 6) * VECS[v].per + 100; w++) begin
          if (running) break;
          cyc(1);
        end
        chk("R7 running", running, 1);
        chk("R10 run code", state_code, 5);
        chk("R7 clamp released", out_clamp, 0);
        chk("R5 ratio", ratio, VECS[v].exp_ratio);
        chk("R5 ratio_valid", ratio_valid, 1);
        chk("R7 settle edges", edge_at_run - edge_at_rv, SF);
      end else begin
        cyc(8 * VECS[v].per);
        chk("R6 illegal state", state_code, 3);
        chk("R6 illegal valid", ratio_valid, 0);
      end
    end

    // R8 power-down bit from run
    bring_up(128);
    cyc((SF + 6) * 128);
    chk("R7 run before pdn", running, 1);
    pdn_bit = 1'b1;
    cyc(1);
    chk("R8 state", state_code, 0);
    chk("R8 clamp", out_clamp, 1);
    chk("R8 power", conv_pwr_en, 0);
    chk("R8 filt_reset", filt_reset, 1);

    // R9 clock loss from run
    bring_up(192);
    cyc((SF + 6) * 192);
    chk("R7 run before loss", running, 1);
    mclk_ok = 1'b0;
    cyc(1);
    chk("R9 state", state_code, 1);
    chk("R9 power", conv_pwr_en, 0);
    chk("R9 valid", ratio_valid, 0);
    chk("R9 clamp", out_clamp, 1);

    // R8 enable loss
    chip_enable = 1'b0;
    cyc(1);
    chk("R8 enable loss state", state_code, 0);
    cyc(1);
    chk("R2 port follows", ctrl_port_en, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule